// File: doc/BRIEF.md
# Start-Detecting 12-Bit Symbol Receiver

This block receives a sliced serial data stream from a radio front end and turns it into 12-bit symbols for a host. While enabled it hunts for a start pattern: the line held high for eight bit times, then eight single bits that alternate, beginning with a low bit. When that pattern is seen it raises a sticky start flag. The host can use this flag as a wake-up interrupt.

Once locked, the block tracks bit timing from the data edges. Every edge realigns a phase counter so that each bit is sampled near its centre. When no edges arrive, the counter keeps running freely. The final high preamble bit is skipped. Each data bit after it is shifted in, and every twelve bits form one symbol. The symbol is held until the host pulses a read strobe: its falling edge copies the symbol to the output register and clears the ready flag. The block never detects the end of a message. Reception stops only when the host clears the start flag.

Top module: `rx_sym_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sym_ready`, `start_det` and `sym_out` become 0.
- R2: A high run of 8 bit times (320 clocks, accepted within ±4 clocks), followed by seven alternating bits of 40 (±4) clocks starting low, sets `start_det`. It is set within 5 clocks of the edge that opens the eighth (high) preamble bit, and not before that edge.
- R3: A high run more than 4 clocks away from 320 clocks does not set `start_det`, even when a correct alternating sequence follows it.
- R4: An alternating preamble bit whose length is more than 4 clocks away from 40 aborts the hunt, and `start_det` stays 0.
- R5: The hunt runs only while `rx_en` is 1. A full, correct preamble sent with `rx_en` low leaves `start_det` at 0.
- R6: `start_det` stays 1 until `start_clr` is sampled high; it then drops on the next edge. After that, no new symbol raises `sym_ready`.
- R7: After lock, the bit following the final preamble bit is the first data bit. Bits are sampled at mid-bit and shifted in MSB first, so the first bit lands in bit 11. Every twelfth bit raises `sym_ready` (active high) with the assembled symbol.
- R8: A 1-to-0 transition on `rd_strobe` copies the held symbol to `sym_out` and clears `sym_ready`. `sym_out` changes at no other time.
- R9: Every input edge realigns the sampling phase. Symbols sent at 39 or 41 clocks per bit, and symbols made only of ones or only of zeros at 40 clocks per bit, are received without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 40 cycles per bit |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_en | input | 1 | Enables the start-pattern hunt |
| rx_in | input | 1 | Sliced serial data, active high, asynchronous |
| rd_strobe | input | 1 | Host read; a falling edge transfers the symbol |
| start_clr | input | 1 | Clears the start flag and stops reception, active high |
| sym_out | output | 12 | Last symbol transferred to the host |
| sym_ready | output | 1 | A new symbol is waiting to be read |
| start_det | output | 1 | Sticky start-pattern flag |

## Verification
The main symbol path is exercised with a table of symbols:
- Balanced symbols, which contain frequent edges and show that the phase realignment keeps samples centred.
- Symbols made of all zeros and all ones, which contain no edges and show that the free-running counter alone frames twelve bits correctly.
- Runs at 39 and 41 clocks per bit, which separate a design that realigns on edges from one that only counts.

The start hunt is tried with four kinds of input:
- An exact preamble, and one with a slightly long high run.
- High runs that are too short and too long.
- A preamble with one stretched alternating bit.
- A correct preamble sent while the block is disabled.

These show that both the length windows and the enable are applied. The timing of the start flag is checked on both sides of the seventh alternating edge.

// File: rtl/rx_sym_pkg.sv
package rx_sym_pkg;

    localparam int BIT_CLKS_D = 40;  // clocks per bit
    localparam int SYM_W_D    = 12;  // bits per symbol
    localparam int PRE_BITS_D = 8;   // high-run length and alternating count, in bits
    localparam int TOL_D      = 4;   // accepted deviation of any run, in clocks

    typedef enum logic [1:0] {
        HUNT_IDLE,
        HUNT_HIGH,
        HUNT_ALT,
        HUNT_LOCK
    } hunt_e;

    function automatic logic in_window(input int unsigned len,
                                       input int unsigned nom,
                                       input int unsigned tol);
        return (len + tol >= nom) && (len <= nom + tol);
    endfunction

endpackage

// File: rtl/rx_sym_sync.sv
module rx_sym_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic edge_p
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    assign level  = pipe[STAGES-1];
    assign edge_p = pipe[STAGES] ^ pipe[STAGES-1];
endmodule

// File: rtl/rx_sym_hunt.sv
module rx_sym_hunt
    import rx_sym_pkg::*;
#(
    parameter int BIT_CLKS = BIT_CLKS_D,
    parameter int PRE_BITS = PRE_BITS_D,
    parameter int TOL      = TOL_D
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic level,
    input  logic edge_p,
    output logic locked
);
    localparam int HIGH_NOM = PRE_BITS * BIT_CLKS;
    localparam int RUN_MAX  = HIGH_NOM + TOL + 1;
    localparam int RUN_W    = $clog2(RUN_MAX + 1);
    localparam int EDGE_W   = $clog2(PRE_BITS);
    localparam int ALT_LAST = PRE_BITS - 2;  // edge count already seen when the final edge arrives

    hunt_e             state;
    logic [RUN_W-1:0]  run;
    logic [EDGE_W-1:0] alt_n;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= HUNT_IDLE;
            run   <= '0;
            alt_n <= '0;
        end else begin
            case (state)
                HUNT_IDLE: begin
                    if (en && level) begin
                        state <= HUNT_HIGH;
                        run   <= RUN_W'(1);
                    end
                end
                HUNT_HIGH: begin
                    if (!en) begin
                        state <= HUNT_IDLE;
                    end else if (edge_p) begin
                        if (in_window(32'(run), HIGH_NOM, TOL)) begin
                            state <= HUNT_ALT;
                            run   <= RUN_W'(1);
                            alt_n <= '0;
                        end else begin
                            state <= HUNT_IDLE;
                        end
                    end else if (run != RUN_W'(RUN_MAX)) begin
                        run <= run + 1'b1;
                    end
                end
                HUNT_ALT: begin
                    if (!en) begin
                        state <= HUNT_IDLE;
                    end else if (edge_p) begin
                        if (!in_window(32'(run), BIT_CLKS, TOL)) begin
                            state <= HUNT_IDLE;
                        end else if (alt_n == EDGE_W'(ALT_LAST)) begin
                            state <= HUNT_LOCK;
                        end else begin
                            alt_n <= alt_n + 1'b1;
                            run   <= RUN_W'(1);
                        end
                    end else if (32'(run) > BIT_CLKS + TOL) begin
                        state <= HUNT_IDLE;
                    end else begin
                        run <= run + 1'b1;
                    end
                end
                default: state <= HUNT_LOCK;
            endcase
        end
    end

    assign locked = (state == HUNT_LOCK);
endmodule

// File: rtl/rx_sym_frame.sv
module rx_sym_frame
    import rx_sym_pkg::*;
#(
    parameter int BIT_CLKS = BIT_CLKS_D,
    parameter int SYM_W    = SYM_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked,
    input  logic             level,
    input  logic             edge_p,
    input  logic             rd,
    output logic [SYM_W-1:0] sym_out,
    output logic             ready
);
    localparam int HALF  = BIT_CLKS / 2;
    localparam int CNT_W = $clog2(BIT_CLKS);
    localparam int NB_W  = $clog2(SYM_W);

    logic [CNT_W-1:0] phase;
    logic [NB_W-1:0]  nbits;
    logic             skip;
    logic             rd_q;
    logic [SYM_W-1:0] shreg;
    logic [SYM_W-1:0] hold;

    logic samp, take, done, rd_fall;
    logic [SYM_W-1:0] shnext;

    assign samp    = locked && !edge_p && (phase == CNT_W'(BIT_CLKS - 1));
    assign take    = samp && !skip;
    assign done    = take && (nbits == NB_W'(SYM_W - 1));
    assign rd_fall = rd_q && !rd;
    assign shnext  = {shreg[SYM_W-2:0], level};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= '0;
            nbits   <= '0;
            skip    <= 1'b1;
            rd_q    <= 1'b0;
            shreg   <= '0;
            hold    <= '0;
            sym_out <= '0;
            ready   <= 1'b0;
        end else begin
            rd_q <= rd;
            if (!locked) begin
                phase <= CNT_W'(HALF);
                skip  <= 1'b1;
                nbits <= '0;
            end else if (edge_p) begin
                phase <= CNT_W'(HALF);
            end else if (samp) begin
                phase <= '0;
                skip  <= 1'b0;
            end else begin
                phase <= phase + 1'b1;
            end

            if (take) begin
                shreg <= shnext;
                nbits <= done ? '0 : nbits + 1'b1;
            end
            if (done) hold <= shnext;

            if (done)         ready <= 1'b1;
            else if (rd_fall) ready <= 1'b0;

            if (rd_fall) sym_out <= hold;
        end
    end
endmodule

// File: rtl/rx_sym_top.sv
module rx_sym_top
    import rx_sym_pkg::*;
#(
    parameter int BIT_CLKS = BIT_CLKS_D,
    parameter int SYM_W    = SYM_W_D,
    parameter int PRE_BITS = PRE_BITS_D,
    parameter int TOL      = TOL_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             rx_in,
    input  logic             rd_strobe,
    input  logic             start_clr,
    output logic [SYM_W-1:0] sym_out,
    output logic             sym_ready,
    output logic             start_det
);
    logic level, edge_p;

    rx_sym_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .level(level), .edge_p(edge_p)
    );

    rx_sym_hunt #(.BIT_CLKS(BIT_CLKS), .PRE_BITS(PRE_BITS), .TOL(TOL)) u_hunt (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .clr(start_clr),
        .level(level), .edge_p(edge_p), .locked(start_det)
    );

    rx_sym_frame #(.BIT_CLKS(BIT_CLKS), .SYM_W(SYM_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .locked(start_det), .level(level),
        .edge_p(edge_p), .rd(rd_strobe), .sym_out(sym_out), .ready(sym_ready)
    );
endmodule

// File: rtl/rx_sym_chk.sv
module rx_sym_chk #(
    parameter int SYM_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             rd_strobe,
    input logic             start_clr,
    input logic [SYM_W-1:0] sym_out,
    input logic             sym_ready,
    input logic             start_det
);
    // R6
    start_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_det) |-> $past(start_clr));

    // R5
    start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_det) |-> $past(rx_en));

    // R7
    ready_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sym_ready) |-> $past(start_det));

    // R8
    ready_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sym_ready) |-> ($past(rd_strobe, 2) && !$past(rd_strobe)));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(rd_strobe) && !rd_strobe) |=> $stable(sym_out));
endmodule

bind rx_sym_top rx_sym_chk #(.SYM_W(SYM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_strobe(rd_strobe),
    .start_clr(start_clr), .sym_out(sym_out), .sym_ready(sym_ready),
    .start_det(start_det)
);

// File: tb/sim_rx_sym_top.sv
module sim_rx_sym_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {symbol, clocks per bit}
    localparam logic [17:0] VEC [NVEC] = '{
        {12'b010101_110001, 6'd40},
        {12'b000111111110,  6'd40},
        {12'h000,           6'd40},
        {12'hFFF,           6'd40},
        {12'b110010_100011, 6'd41},
        {12'b101010101010,  6'd41},
        {12'b011010_001110, 6'd39},
        {12'b100110_011100, 6'd39}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0, rx_en = 1'b0, rx_in = 1'b0, rd_strobe = 1'b0, start_clr = 1'b0;
    logic [11:0] sym_out;
    logic sym_ready, start_det;
    int tests = 0, failed = 0;

    rx_sym_top u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_in(rx_in),
        .rd_strobe(rd_strobe), .start_clr(start_clr),
        .sym_out(sym_out), .sym_ready(sym_ready), .start_det(start_det)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx_in = v;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic preamble(input int hi, input int alt, input int brk);
        hold(1'b1, hi);
        for (int k = 0; k < 8; k++) hold(k[0], (k == brk) ? 80 : alt);
    endtask

    task automatic pulse_clr();
        start_clr = 1'b1; @(posedge clk); #1; start_clr = 1'b0;
        repeat (2) begin @(posedge clk); #1; end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_in = 1'b0;
        repeat (5) begin @(posedge clk); #1; end
        rst_n = 1'b1;
        repeat (2) begin @(posedge clk); #1; end
    endtask

    task automatic read_sym();
        rd_strobe = 1'b1;
        repeat (2) begin @(posedge clk); #1; end
        rd_strobe = 1'b0;
        repeat (2) begin @(posedge clk); #1; end
    endtask

    task automatic wait_ready(input int limit);
        int n = 0;
        while (!sym_ready && n < limit) begin @(posedge clk); #1; n++; end
        check("R7 ready raised", sym_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failed++;
        $display("FAIL R7 watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (3) begin @(posedge clk); #1; end
        // R1 reset state
        check("R1 ready", sym_ready, 0);
        check("R1 start", start_det, 0);
        check("R1 sym_out", sym_out, 0);
        do_reset();
        rx_en = 1'b1;

        // R3 high run too short and too long
        preamble(240, 40, -1); hold(0, 100);
        check("R3 short run", start_det, 0);
        preamble(330, 40, -1); hold(0, 100);
        check("R3 long run", start_det, 0);

        // R4 stretched alternating bit
        preamble(320, 40, 3); hold(0, 100);
        check("R4 bad alt bit", start_det, 0);

        // R5 disabled
        rx_en = 1'b0;
        preamble(320, 40, -1); hold(0, 100);
        check("R5 disabled hunt", start_det, 0);
        rx_en = 1'b1; hold(0, 50);

        // R2 lock timing, high run at +3 tolerance
        hold(1'b1, 323);
        for (int k = 0; k < 7; k++) hold(k[0], 40);
        check("R2 before last edge", start_det, 0);
        hold(1'b1, 5);
        check("R2 after last edge", start_det, 1);
        hold(1'b1, 35);
        // R6 sticky then clear
        hold(1'b0, 600);
        check("R6 sticky", start_det, 1);
        pulse_clr();
        check("R6 cleared", start_det, 0);

        // R7 R8 R9 symbol table
        do_reset();
        rx_en = 1'b1;
        hold(0, 40);
        fork
            begin
                preamble(320, 40, -1);
                for (int i = 0; i < NVEC; i++)
                    for (int b = 11; b >= 0; b--) hold(VEC[i][6+b], int'(VEC[i][5:0]));
            end
            begin
                for (int i = 0; i < NVEC; i++) begin
                    wait_ready(2000);
                    read_sym();
                    check($sformatf("R7 R9 symbol %0d", i), sym_out, VEC[i][17:6]);
                    check("R8 ready cleared", sym_ready, 0);
                end
            end
        join

        // R6 reception stops after clear
        pulse_clr();
        check("R6 cleared after data", start_det, 0);
        read_sym();
        check("R8 ready cleared by read", sym_ready, 0);
        for (int b = 0; b < 14; b++) hold(b[0], 40);
        check("R6 no ready after clear", sym_ready, 0);
        check("R8 sym_out unchanged", sym_out, VEC[NVEC-1][17:6]);

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule